// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Unit

This block is the hazard controller of a five-stage in-order pipeline. When the instruction in decode reads a register that the load now in execute is about to fetch from memory, the loaded value cannot be forwarded in time. The unit then freezes fetch and decode for one cycle and sends a bubble into execute in place of the decoded instruction's control bits. Only the instruction directly behind the load is compared. A consumer further back gets its operand through the forwarding paths.

Branches are assumed not taken and are resolved in decode. When a branch is found to be taken, or the decode stage holds a jump, the one instruction fetched behind it is wrong. The unit raises a flush so that the fetch-to-decode register loads an all-zero no-op on the next edge. A jump therefore always costs one cycle, and a load-use pair costs one cycle.

Top module: `hazard_ctl_unit`

## Requirements
- R1: A stall is raised when `ex_mem_rd` is 1 and `ex_dst` is nonzero and equal to `dec_src_a`.
- R2: A stall is raised under the same conditions when `ex_dst` equals `dec_src_b`.
- R3: With `ex_mem_rd` at 0, matching register fields cause no stall. Such a producer is served by forwarding.
- R4: A load whose `ex_dst` is register 0 never causes a stall, whatever the source fields hold.
- R5: While stalled, `pc_we` and `ifid_we` are 0 and `bubble_sel` is 1. In every other cycle `pc_we` and `ifid_we` are 1 and `bubble_sel` is 0.
- R6: A stall lasts exactly one cycle. In the cycle after a stall, no stall is raised even if the inputs still show the same load-use match.
- R7: A taken branch in decode (`dec_br_taken` = 1) raises `ifid_flush` in the same cycle when there is no stall.
- R8: A jump in decode (`dec_jump` = 1) raises `ifid_flush` in the same cycle when there is no stall.
- R9: A stall takes precedence over a flush. While stalled, `ifid_flush` is 0. In the next cycle, a branch still held in decode raises the flush.
- R10: Reset clears the stall history. After reset, idle inputs give `pc_we` = 1, `ifid_we` = 1, `bubble_sel` = 0 and `ifid_flush` = 0, and a load-use match stalls at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | AW | First source register field of the decode instruction |
| dec_src_b | input | AW | Second source register field of the decode instruction |
| ex_dst | input | AW | Load destination register field in execute |
| ex_mem_rd | input | 1 | Execute instruction reads memory (is a load) |
| dec_br_taken | input | 1 | Branch in decode resolved taken |
| dec_jump | input | 1 | Decode instruction is an unconditional jump |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch-to-decode register write enable |
| bubble_sel | output | 1 | Select zeroed control bits into execute |
| ifid_flush | output | 1 | Load an all-zero no-op into fetch-to-decode |

## Verification
The stall and the flush can fall in the same cycle. This happens when a taken branch in decode reads the register of the load ahead of it. The bench provokes it by asserting a load-use match and `dec_br_taken` together. It expects the stall outputs with the flush held low in that cycle. In the following cycle it holds the same inputs and expects the flush alone, with both write enables high.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Grouped control outputs of the hazard unit
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
    logic flush;
  } hz_ctl_t;

  // Control word when nothing stalls or redirects
  localparam hz_ctl_t HZ_CTL_RUN = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0, flush: 1'b0};
endpackage

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
  parameter int unsigned AW = 5
) (
  input  logic          ex_mem_rd,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  // A nonzero destination feeds a source when both fields agree
  function automatic logic dst_feeds(input logic [AW-1:0] dst, input logic [AW-1:0] src);
    return (dst != ZERO_REG) && (dst == src);
  endfunction

  always_comb begin
    hit = ex_mem_rd && (dst_feeds(ex_dst, dec_src_a) || dst_feeds(ex_dst, dec_src_b));
  end
endmodule

// File: rtl/hz_stall_gate.sv
module hz_stall_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic stall,
  output logic stalled_last
);
  // The bubble now sits in execute, so a repeated match is stale
  always_comb stall = hit && !stalled_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_last <= 1'b0;
    else        stalled_last <= stall;
  end
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic br_taken,
  input  logic jump,
  input  logic stall,
  output logic redirect_req,
  output logic flush
);
  always_comb begin
    redirect_req = br_taken || jump;
    // Stall wins: the branch stays in decode and flushes next cycle
    flush        = redirect_req && !stall;
  end
endmodule

// File: rtl/hazard_ctl_unit.sv
module hazard_ctl_unit #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_src_a,
  input  logic [AW-1:0] dec_src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_mem_rd,
  input  logic          dec_br_taken,
  input  logic          dec_jump,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          bubble_sel,
  output logic          ifid_flush
);
  import hz_pkg::*;

  logic    lu_hit;
  logic    stall;
  logic    stalled_last;
  logic    redirect_req;
  logic    flush;
  hz_ctl_t ctl;

  hz_loaduse_detect #(.AW(AW)) u_detect (
    .ex_mem_rd (ex_mem_rd),
    .ex_dst    (ex_dst),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .hit       (lu_hit)
  );

  hz_stall_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (lu_hit),
    .stall        (stall),
    .stalled_last (stalled_last)
  );

  hz_redirect u_redir (
    .br_taken     (dec_br_taken),
    .jump         (dec_jump),
    .stall        (stall),
    .redirect_req (redirect_req),
    .flush        (flush)
  );

  always_comb begin
    ctl = HZ_CTL_RUN;
    if (stall) begin
      ctl.pc_we   = 1'b0;
      ctl.ifid_we = 1'b0;
      ctl.bubble  = 1'b1;
    end
    ctl.flush = flush;
  end

  assign pc_we      = ctl.pc_we;
  assign ifid_we    = ctl.ifid_we;
  assign bubble_sel = ctl.bubble;
  assign ifid_flush = ctl.flush;
endmodule

// File: rtl/hz_ctl_checker.sv
module hz_ctl_checker #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ex_dst,
  input logic          ex_mem_rd,
  input logic          lu_hit,
  input logic          redirect_req,
  input logic          stalled_last,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          bubble_sel,
  input logic          ifid_flush
);
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> (!pc_we && !ifid_we));

  p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bubble_sel |-> (pc_we && ifid_we));

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> !bubble_sel);

  p_fresh_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_hit && !stalled_last) |-> bubble_sel);

  p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_rd |-> !bubble_sel);

  p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0) |-> !bubble_sel);

  p_stall_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |-> !ifid_flush);

  p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_req && !bubble_sel) |-> ifid_flush);
endmodule

bind hazard_ctl_unit hz_ctl_checker #(.AW(AW)) u_hz_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ex_dst       (ex_dst),
  .ex_mem_rd    (ex_mem_rd),
  .lu_hit       (lu_hit),
  .redirect_req (redirect_req),
  .stalled_last (stalled_last),
  .pc_we        (pc_we),
  .ifid_we      (ifid_we),
  .bubble_sel   (bubble_sel),
  .ifid_flush   (ifid_flush)
);

// File: tb/test_hazard_ctl_unit.sv
module test_hazard_ctl_unit;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, ex_dst = '0;
  logic          ex_mem_rd = 1'b0, dec_br_taken = 1'b0, dec_jump = 1'b0;
  logic          pc_we, ifid_we, bubble_sel, ifid_flush;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Expected words {pc_we, ifid_we, bubble_sel, ifid_flush}
  localparam logic [3:0] E_RUN   = 4'b1100;
  localparam logic [3:0] E_STALL = 4'b0010;
  localparam logic [3:0] E_FLUSH = 4'b1101;

  always #2 clk = ~clk;

  hazard_ctl_unit #(.AW(AW)) i_hazard_ctl_unit (
    .clk (clk), .rst_n (rst_n),
    .dec_src_a (dec_src_a), .dec_src_b (dec_src_b),
    .ex_dst (ex_dst), .ex_mem_rd (ex_mem_rd),
    .dec_br_taken (dec_br_taken), .dec_jump (dec_jump),
    .pc_we (pc_we), .ifid_we (ifid_we),
    .bubble_sel (bubble_sel), .ifid_flush (ifid_flush)
  );

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_we, ifid_we, bubble_sel, ifid_flush};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Apply inputs just after a falling edge; outputs settle before sampling
  task automatic apply(input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic [AW-1:0] d, input logic mr,
                       input logic bt, input logic jp);
    @(negedge clk);
    dec_src_a = a; dec_src_b = b; ex_dst = d;
    ex_mem_rd = mr; dec_br_taken = bt; dec_jump = jp;
    #1;
  endtask

  task automatic idle();
    apply('0, '0, '0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle();
    check("R10 reset outputs", E_RUN);
    @(negedge clk); rst_n = 1'b1;
    idle();
    check("R10 idle after reset", E_RUN);
  endtask

  task automatic t_src_a();
    idle();
    apply(5'd7, 5'd3, 5'd7, 1'b1, 1'b0, 1'b0);
    check("R1 match on src_a", E_STALL);
    idle();
    apply(5'd31, 5'd0, 5'd31, 1'b1, 1'b0, 1'b0);
    check("R1 match highest reg", E_STALL);
  endtask

  task automatic t_src_b();
    idle();
    apply(5'd4, 5'd9, 5'd9, 1'b1, 1'b0, 1'b0);
    check("R2 match on src_b", E_STALL);
    idle();
    apply(5'd4, 5'd9, 5'd10, 1'b1, 1'b0, 1'b0);
    check("R2 load with no match", E_RUN);
  endtask

  task automatic t_no_load();
    idle();
    apply(5'd6, 5'd6, 5'd6, 1'b0, 1'b0, 1'b0);
    check("R3 non-load match", E_RUN);
  endtask

  task automatic t_zero_reg();
    idle();
    apply(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0);
    check("R4 load to reg0", E_RUN);
  endtask

  task automatic t_one_cycle();
    idle();
    apply(5'd12, 5'd1, 5'd12, 1'b1, 1'b0, 1'b0);
    check("R5 R6 first cycle stalls", E_STALL);
    apply(5'd12, 5'd1, 5'd12, 1'b1, 1'b0, 1'b0);
    check("R6 stall released next cycle", E_RUN);
  endtask

  task automatic t_branch();
    idle();
    apply(5'd2, 5'd3, 5'd0, 1'b0, 1'b1, 1'b0);
    check("R7 taken branch flush", E_FLUSH);
    apply(5'd2, 5'd3, 5'd0, 1'b0, 1'b0, 1'b0);
    check("R7 not-taken no flush", E_RUN);
  endtask

  task automatic t_jump();
    idle();
    apply(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1);
    check("R8 jump flush", E_FLUSH);
  endtask

  task automatic t_priority();
    idle();
    apply(5'd8, 5'd2, 5'd8, 1'b1, 1'b1, 1'b0);
    check("R9 stall beats flush", E_STALL);
    apply(5'd8, 5'd2, 5'd8, 1'b1, 1'b1, 1'b0);
    check("R9 flush after stall", E_FLUSH);
    idle();
    apply(5'd5, 5'd8, 5'd8, 1'b1, 1'b0, 1'b1);
    check("R9 stall beats jump", E_STALL);
  endtask

  task automatic t_reset_history();
    idle();
    apply(5'd14, 5'd0, 5'd14, 1'b1, 1'b0, 1'b0);
    check("R10 stall before reset", E_STALL);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 stall again after reset", E_STALL);
  endtask

  initial begin
    t_reset();
    t_src_a();
    t_src_b();
    t_no_load();
    t_zero_reg();
    t_one_cycle();
    t_branch();
    t_jump();
    t_priority();
    t_reset_history();
    idle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule